// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the output side of a sampling analog-to-digital converter's serial result interface. A conversion core delivers each finished 16-bit word on a parallel input with a one-cycle strobe. The block keeps the last finished word in an output register and sends it out one bit at a time on `sdata_o`, most significant bit first. It also drives the conversion-busy flag and decides when a conversion request is accepted. A request is chip select low together with the read/convert line low.

A mode input picks the data clock. With the mode low, every accepted request starts a burst of 16 pulses on `dclk_o`, made by dividing the system clock. That burst carries the word from the conversion before the one just started. When the burst is over, `sdata_o` holds the daisy-chain level that was sampled from `tag_i` on the first pulse. With the mode high, `dclk_o` stays low and a host clocks the data out on `dclk_ext_i` while chip select is low and read/convert is high. On each of those edges `tag_i` enters the far end of the shift path, so levels from a downstream device follow the 16 result bits.

Top module: `adc_serial_port`

## Requirements
- R1: With `ext_clk_mode_i` high (1 = external clock, 0 = internal clock), `dclk_o` stays low and bits advance only on `dclk_ext_i` rising edges.
- R2: A request (`cs_ni` = 0 and `rc_i` = 0) seen while `busy_o` is high starts a conversion, and `busy_o` is low in the next cycle. In internal mode it launches exactly 16 `dclk_o` pulses. A request seen while `busy_o` is low is ignored.
- R3: An internal burst carries, MSB first, the word held in the output register when the request was accepted (conversion n-1), never the word of the conversion just started.
- R4: The first bit is on `sdata_o` from the cycle after the start. Each later bit appears one system cycle after the falling edge of the pulse before it, so `sdata_o` does not change on any rising or falling edge of `dclk_o`.
- R5: After the 16th pulse, `dclk_o` stays low until the next accepted request.
- R6: After the 16th internal bit, `sdata_o` shows the `tag_i` level captured at the first rising edge of that burst. Later changes on `tag_i` do not affect it.
- R7: Each high and low phase of `dclk_o` lasts `HALF_DIV` system cycles. The first rising edge comes `HALF_DIV` cycles after the start edge.
- R8: `busy_o` rises when a finished word is moved into the output register, two cycles after the strobe at the earliest. It never rises before the 16th pulse and its bit shift are done. A word arriving during the burst waits.
- R9: In external mode a finished word goes straight onto `sdata_o`, MSB first. With `cs_ni` = 0 and `rc_i` = 1, each synchronized rising edge of `dclk_ext_i` moves to the next bit and shifts `tag_i` in at the LSB, so the tag levels follow after 16 edges. Edges seen with the window closed change nothing.
- R10: Reset (`rst_ni` low) clears the output register and `sdata_o` to 0, drives `dclk_o` low and `busy_o` high.
- R11: `sdata_o` is always driven to a known level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_mode_i | input | 1 | Data clock source: 0 internal, 1 external |
| cs_ni | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read/convert: 0 requests a conversion, 1 opens the read window |
| tag_i | input | 1 | Daisy-chain data input |
| dclk_ext_i | input | 1 | Host-supplied data clock (asynchronous) |
| result_i | input | WORD_W | Finished word from the conversion core |
| result_valid_i | input | 1 | One-cycle strobe: `result_i` is valid |
| dclk_o | output | 1 | Internally generated data clock |
| sdata_o | output | 1 | Serial data, always driven |
| busy_o | output | 1 | Low while a conversion is in progress |

## Verification
The assertions check on every cycle that `busy_o` stays low through an internal burst and rises only after it. They also check that `sdata_o` never changes on a `dclk_o` edge, that `sdata_o` is never unknown, that an accepted request drops `busy_o`, and that a burst ends on its 16th falling edge. Only the bench scenarios can show the other properties. These are the n-1 word order across back-to-back conversions, the tag level latched at the first pulse even when `tag_i` changes later, the phase lengths, and results arriving during or after a burst. They also include a request ignored in mid-burst, external-mode shifting with tag fill-in, and a closed window ignoring host clock edges.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } dclk_src_e;

  localparam int unsigned MIN_HALF_DIV = 2;
endpackage

// File: rtl/adc_sp_burst_gen.sv
module adc_sp_burst_gen #(
  parameter int unsigned NUM_PULSES = 16,
  parameter int unsigned HALF_DIV   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic dclk_o,
  output logic active_o,
  output logic first_rise_o,
  output logic fall_o
);
  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned CNT_W = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;

  logic             active_q, phase_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] pcnt_q;
  logic             half_end;

  assign half_end     = active_q && (div_q == DIV_W'(HALF_DIV - 1));
  assign first_rise_o = half_end && !phase_q && (pcnt_q == '0);
  assign fall_o       = half_end && phase_q;
  assign dclk_o       = phase_q;
  assign active_o     = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      div_q    <= '0;
      pcnt_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      div_q    <= '0;
      pcnt_q   <= '0;
    end else if (active_q) begin
      if (half_end) begin
        div_q   <= '0;
        phase_q <= ~phase_q;
        if (phase_q) begin
          pcnt_q <= pcnt_q + 1'b1;
          if (pcnt_q == CNT_W'(NUM_PULSES - 1)) active_q <= 1'b0;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R2: burst terminates on its last falling edge
  a_r2_burst_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o && pcnt_q == CNT_W'(NUM_PULSES - 1) && !start_i) |=> (!active_o && !dclk_o));
endmodule

// File: rtl/adc_sp_edge_sync.sv
module adc_sp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], async_i};
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/adc_sp_shifter.sv
module adc_sp_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              out_load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sh_from_out_i,
  input  logic              sh_from_word_i,
  input  logic              sh_step_i,
  input  logic              sh_fill_i,
  output logic              sdata_o
);
  logic [WORD_W-1:0] out_q, sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         out_q <= '0;
    else if (out_load_i) out_q <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             sh_q <= '0;
    else if (sh_from_out_i)  sh_q <= out_q;
    else if (sh_from_word_i) sh_q <= word_i;
    else if (sh_step_i)      sh_q <= {sh_q[WORD_W-2:0], sh_fill_i};
  end

  assign sdata_o = sh_q[WORD_W-1];

  // R3: burst opens with the MSB of the previously stored word
  a_r3_prev_word_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_from_out_i && !out_load_i) |=> (sdata_o == $past(out_q[WORD_W-1])));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_mode_i,
  input  logic              cs_ni,
  input  logic              rc_i,
  input  logic              tag_i,
  input  logic              dclk_ext_i,
  input  logic [WORD_W-1:0] result_i,
  input  logic              result_valid_i,
  output logic              dclk_o,
  output logic              sdata_o,
  output logic              busy_o
);
  localparam int unsigned NUM_PULSES = WORD_W;

  dclk_src_e         src;
  logic              busy_q, pend_q, tag_q, shift_stb_q;
  logic [WORD_W-1:0] word_q;
  logic              start_req, burst_start, load_ok, rd_window;
  logic              burst_active, first_rise, fall_stb, ext_rise, ext_step;
  logic              sh_step, sh_fill;

  assign src         = dclk_src_e'(ext_clk_mode_i);
  assign start_req   = !cs_ni && !rc_i && busy_q;
  assign burst_start = start_req && (src == SRC_INTERNAL);
  assign load_ok     = pend_q && !busy_q && !burst_active && !shift_stb_q;
  assign rd_window   = !cs_ni && rc_i;
  assign ext_step    = (src == SRC_EXTERNAL) && rd_window && ext_rise && !load_ok;
  assign sh_step     = (src == SRC_INTERNAL) ? shift_stb_q : ext_step;
  assign sh_fill     = (src == SRC_INTERNAL) ? tag_q : tag_i;
  assign busy_o      = busy_q;

  adc_sp_burst_gen #(.NUM_PULSES(NUM_PULSES), .HALF_DIV(HALF_DIV)) u_burst (
    .clk_i, .rst_ni,
    .start_i     (burst_start),
    .dclk_o      (dclk_o),
    .active_o    (burst_active),
    .first_rise_o(first_rise),
    .fall_o      (fall_stb)
  );

  adc_sp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .async_i(dclk_ext_i),
    .rise_o (ext_rise)
  );

  adc_sp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni,
    .out_load_i    (load_ok),
    .word_i        (word_q),
    .sh_from_out_i (burst_start),
    .sh_from_word_i(load_ok && (src == SRC_EXTERNAL)),
    .sh_step_i     (sh_step),
    .sh_fill_i     (sh_fill),
    .sdata_o       (sdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b1;
      pend_q      <= 1'b0;
      word_q      <= '0;
      tag_q       <= 1'b0;
      shift_stb_q <= 1'b0;
    end else begin
      // shift one cycle after each fall keeps bits off both clock edges
      shift_stb_q <= fall_stb;
      if (first_rise) tag_q <= tag_i;
      if (start_req)    busy_q <= 1'b0;
      else if (load_ok) busy_q <= 1'b1;
      if (load_ok) begin
        pend_q <= 1'b0;
      end else if (result_valid_i && !busy_q) begin
        pend_q <= 1'b1;
        word_q <= result_i;
      end
    end
  end

  a_r2_start_drops_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req |=> !busy_o);
  a_r8_busy_low_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_active |-> !busy_o);
  a_r8_busy_rise_after_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!burst_active && !dclk_o));
  a_r4_bit_stable_on_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dclk_o) || $fell(dclk_o)) |-> $stable(sdata_o));
  a_r11_sdata_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(sdata_o));
endmodule

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 4;
  localparam int W          = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode = 1'b0, cs_n = 1'b1, rc = 1'b1, tag = 1'b0, dclk_ext = 1'b0, rvalid = 1'b0;
  logic [W-1:0] rdata = '0;
  logic dclk, sdata, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port #(.WORD_W(W), .HALF_DIV(HALF_DIV), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ext_clk_mode_i(mode), .cs_ni(cs_n), .rc_i(rc),
    .tag_i(tag), .dclk_ext_i(dclk_ext), .result_i(rdata), .result_valid_i(rvalid),
    .dclk_o(dclk), .sdata_o(sdata), .busy_o(busy)
  );

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] model_out = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: gathers burst bits, pops the scoreboard
  int mon_cnt = 0, hi_len = 0;
  logic [W-1:0] mon_bits = '0, exp_w;
  logic prev_dclk = 1'b0, prev_busy = 1'b1, prev_sdata = 1'b0, last_bit = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_busy && !busy) mon_cnt = 0;
      if (dclk && !prev_dclk) begin
        chk(sdata == prev_sdata, "R4 bit held over rising edge", sdata, prev_sdata);
        if (mon_cnt >= W) chk(1'b0, "R2 extra pulse", mon_cnt, W);
        else begin
          mon_bits = {mon_bits[W-2:0], sdata};
          last_bit = sdata;
          mon_cnt++;
          if (mon_cnt == W) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected burst", mon_bits, 0);
            else begin
              exp_w = exp_q.pop_front();
              chk(mon_bits == exp_w, "R3 burst word", mon_bits, exp_w);
            end
          end
        end
        hi_len = 1;
      end else if (dclk) hi_len++;
      if (!dclk && prev_dclk) begin
        chk(sdata == last_bit, "R4 bit held over falling edge", sdata, last_bit);
        chk(hi_len == HALF_DIV, "R7 high phase length", hi_len, HALF_DIV);
      end
      prev_dclk  = dclk;
      prev_busy  = busy;
      prev_sdata = sdata;
    end
  end

  task automatic int_convert(input logic [W-1:0] nv, input bit tg, input int delay,
                             input bit flip, input bit glitch);
    int first_k = -1;
    exp_q.push_back(model_out);
    tag = tg; cs_n = 1'b0; rc = 1'b0;
    @(negedge clk); rc = 1'b1;
    chk(busy == 1'b0, "R2 busy low after start", busy, 0);
    chk(dclk == 1'b0, "R7 no pulse on start cycle", dclk, 0);
    for (int k = 2; k <= delay; k++) begin
      @(negedge clk);
      if (dclk && first_k < 0) first_k = k;
      if (flip && k == HALF_DIV + 3) tag = ~tg;
      if (glitch && k == 30) rc = 1'b0;
      if (glitch && k == 31) rc = 1'b1;
    end
    chk(first_k == HALF_DIV + 1, "R7 first rise delay", first_k, HALF_DIV + 1);
    chk(busy == 1'b0, "R8 busy low while result outstanding", busy, 0);
    rvalid = 1'b1; rdata = nv;
    @(negedge clk); rvalid = 1'b0;
    chk(busy == 1'b0, "R8 busy low one cycle after strobe", busy, 0);
    if (delay > 8 * W * HALF_DIV / 4 + 20) begin
      @(negedge clk);
      chk(busy == 1'b1, "R8 load latency after burst", busy, 1);
    end
    for (int t = 0; t < 400 && !(mon_cnt == W && !dclk); t++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(mon_cnt == W, "R2 exactly 16 pulses", mon_cnt, W);
    chk(sdata == tg, "R6 sdata carries first-pulse tag", sdata, tg);
    for (int t = 0; t < 400 && !busy; t++) @(negedge clk);
    chk(busy == 1'b1 && mon_cnt == W && !dclk, "R8 busy rises after burst", {busy, dclk}, 2'b10);
    model_out = nv;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      chk(dclk == 1'b0, "R5 dclk idle low", dclk, 0);
    end
    chk(sdata == tg, "R6 tag level held", sdata, tg);
  endtask

  task automatic ext_convert(input logic [W-1:0] nv);
    logic [19:0] tp = 20'h5_A3C6;
    logic expb;
    mode = 1'b1; tag = 1'b0; cs_n = 1'b0; rc = 1'b0;
    @(negedge clk); rc = 1'b1; cs_n = 1'b1;
    chk(busy == 1'b0, "R2 busy low after ext start", busy, 0);
    repeat (5) @(negedge clk);
    chk(dclk == 1'b0, "R1 no internal clock in ext mode", dclk, 0);
    rvalid = 1'b1; rdata = nv;
    @(negedge clk); rvalid = 1'b0;
    for (int t = 0; t < 20 && !busy; t++) @(negedge clk);
    chk(busy == 1'b1, "R8 busy high after ext load", busy, 1);
    chk(sdata == nv[W-1], "R9 word loaded MSB first", sdata, nv[W-1]);
    for (int i = 0; i < 3; i++) begin
      dclk_ext = 1'b1; repeat (6) @(negedge clk);
      dclk_ext = 1'b0; repeat (6) @(negedge clk);
    end
    chk(sdata == nv[W-1], "R9 edges ignored with window closed", sdata, nv[W-1]);
    cs_n = 1'b0; rc = 1'b1;
    for (int i = 0; i < 20; i++) begin
      expb = (i < W) ? nv[W-1-i] : tp[i-W];
      chk(sdata == expb, "R9 external shift bit", sdata, expb);
      tag = tp[i];
      dclk_ext = 1'b1; repeat (6) @(negedge clk);
      dclk_ext = 1'b0; repeat (6) @(negedge clk);
    end
    chk(dclk == 1'b0, "R1 dclk low after external shifting", dclk, 0);
    cs_n = 1'b1; mode = 1'b0;
    model_out = nv;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dclk == 1'b0, "R10 reset dclk low", dclk, 0);
    chk(busy == 1'b1, "R10 reset busy high", busy, 1);
    chk(sdata == 1'b0, "R10 reset sdata zero", sdata, 0);
    chk(!$isunknown(sdata), "R11 sdata driven", sdata, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    int_convert(16'hA5C3, 1'b1, 10, 1'b0, 1'b0);
    int_convert(16'h1234, 1'b0, 40, 1'b1, 1'b1);
    int_convert(16'h8001, 1'b1, 200, 1'b0, 1'b0);
    ext_convert(16'hBEEF);
    int_convert(16'h7FFE, 1'b0, 20, 1'b0, 1'b0);
    chk(exp_q.size() == 0, "R3 every burst observed", exp_q.size(), 0);
    chk(!$isunknown(sdata), "R11 sdata driven at end", sdata, 0);
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule